// File: doc/BRIEF.md
# Lockable Watchdog with Offset Restart

This block is a watchdog built around a free-running 16-bit tick counter. The counter advances on a selectable count tick: the system clock divided by 12, the system clock divided by 4, every system clock, or an externally supplied tick-enable. Software restarts the watchdog by pulsing a restart strobe. The restart places a compare point ahead of the live counter: the compare high byte becomes the counter's current high byte plus an 8-bit offset plus one. If the counter reaches that point before the next restart, the block raises a one-cycle reset request. The request also clears every register of the block back to its reset value.

The watchdog leaves reset enabled, with a short default timeout. Software may turn it off by clearing the enable, then choose the tick source and the idle-suspend option, load the offset, and turn it back on. While the watchdog runs, the tick source and idle-suspend settings are frozen. A sticky lock bit keeps the watchdog on until the next reset. With idle-suspend set, the counter holds whenever the processor reports idle.

Top module: `lockable_watchdog`

## Requirements
- R1: While reset is asserted, and right after it, the block reads as on, unlocked, tick source code 0, idle-suspend off, offset 0, counter 0 and compare high byte 1.
- R2: After reset is released with no further writes, the reset request is first seen after the 3072nd rising clock edge, which is 256 ticks of the divide-by-12 source.
- R3: A restart taken while the counter low byte is L, with offset value F, raises the reset request after exactly 256*F + 256 - L count ticks. The tick that lands on the restart edge counts as the first of these ticks.
- R4: The 3-bit tick source code selects divide-by-12 (0), divide-by-4 (1), every clock (2) or the ext_tick_i input (3). Codes 4 to 7 behave as divide-by-12. With code 3 the counter moves only on clocks where ext_tick_i is high.
- R5: When the lock is clear, a configuration write with the enable bit at 0 turns the watchdog off (wdt_on_o low).
- R6: A configuration write with the lock bit at 1 turns the watchdog on and sets lock_o. After that, writes cannot clear the lock or turn the watchdog off, and timeouts still raise the reset request, until the next reset.
- R7: While the watchdog is on, configuration writes leave the tick source and idle-suspend settings unchanged. While it is off, such writes take effect.
- R8: With idle-suspend set, the counter holds for every clock on which cpu_idle_i is high. With idle-suspend clear, the counter keeps counting during idle.
- R9: The reset request lasts exactly one clock. On the following edge every register returns to its R1 value.
- R10: While the watchdog is off, no reset request occurs and restart strobes leave the compare high byte unchanged.
- R11: An accepted restart loads the compare high byte with (counter high byte + offset + 1) modulo 256, using the values present before the restart edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_tick_i | input | 1 | External count-tick enable, used with source code 3 |
| cpu_idle_i | input | 1 | Processor idle indication |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_en_i | input | 1 | Enable bit written with cfg_we_i |
| cfg_lock_i | input | 1 | Lock bit written with cfg_we_i (sets only) |
| cfg_idle_stop_i | input | 1 | Idle-suspend bit written with cfg_we_i |
| cfg_src_i | input | 3 | Tick source code written with cfg_we_i |
| ofs_we_i | input | 1 | Offset write strobe |
| ofs_i | input | 8 | Offset value |
| kick_i | input | 1 | Restart strobe |
| bite_o | output | 1 | One-cycle reset request |
| wdt_on_o | output | 1 | Watchdog currently on |
| lock_o | output | 1 | Lock bit state |
| idle_stop_o | output | 1 | Idle-suspend setting |
| src_o | output | 3 | Tick source code in force |
| ofs_o | output | 8 | Offset register |
| cnt_o | output | 16 | Live counter value |
| cmp_hi_o | output | 8 | Compare high byte |

## Verification
The bench sweeps restart positions across the counter low byte, including 255. At 255, a design that ignores the restart on the restart edge, or that compares against the old point, would fire 256 ticks early or miss the timeout. It also covers low byte 0 with the largest offset, where a design that truncates the offset sum or mishandles the wrap would time out far too soon. The slower tick sources are measured against their tick windows, so a design that swaps codes or treats unused codes as some other rate falls outside them. The bench tries to turn off a locked watchdog and tries to retune a running one, and afterwards checks that the reset request clears the lock; a sticky bit that survives the request, or a frozen field that still accepts writes, is caught at the status outputs.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

  localparam int SEL_W = 3;

  typedef enum logic [SEL_W-1:0] {
    SRC_DIV12 = 3'd0,
    SRC_DIV4  = 3'd1,
    SRC_SYS   = 3'd2,
    SRC_EXT   = 3'd3
  } src_e;

  typedef struct packed {
    logic             en;
    logic             lock;
    logic             idle_stop;
    logic [SEL_W-1:0] src;
  } cfg_t;

endpackage

// File: rtl/wdt_tick_gen.sv
module wdt_tick_gen
  import wdt_pkg::*;
#(
  parameter int SLOW_DIV = 12,
  parameter int FAST_DIV = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             ext_tick_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             tick_o
);

  localparam int N_DIV = 2;

  logic [N_DIV-1:0] div_tick;

  // One phase counter per divider; index 0 is the slow one.
  for (genvar g = 0; g < N_DIV; g++) begin : g_div
    localparam int D = (g == 0) ? SLOW_DIV : FAST_DIV;
    localparam int W = (D > 1) ? $clog2(D) : 1;
    logic [W-1:0] ph_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ph_q <= '0;
      end else if (clr_i) begin
        ph_q <= '0;
      end else if (ph_q == W'(D - 1)) begin
        ph_q <= '0;
      end else begin
        ph_q <= ph_q + W'(1);
      end
    end

    assign div_tick[g] = (ph_q == W'(D - 1));
  end

  always_comb begin
    case (sel_i)
      SRC_DIV4: tick_o = div_tick[1];
      SRC_SYS:  tick_o = 1'b1;
      SRC_EXT:  tick_o = ext_tick_i;
      default:  tick_o = div_tick[0];
    endcase
  end

endmodule

// File: rtl/wdt_timer.sv
module wdt_timer #(
  parameter int LO_W = 8,
  parameter int HI_W = 8,
  localparam int CNT_W = LO_W + HI_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             tick_i,
  output logic [CNT_W-1:0] cnt_o
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (clr_i) begin
      cnt_q <= '0;
    end else if (tick_i) begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  assign cnt_o = cnt_q;

endmodule

// File: rtl/wdt_ctrl.sv
module wdt_ctrl
  import wdt_pkg::*;
#(
  parameter int LO_W = 8,
  parameter int HI_W = 8,
  localparam int CNT_W = LO_W + HI_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             cfg_we_i,
  input  cfg_t             cfg_i,
  input  logic             ofs_we_i,
  input  logic [HI_W-1:0]  ofs_i,
  input  logic             kick_i,
  output logic             active_o,
  output logic             lock_o,
  output logic             idle_stop_o,
  output logic [SEL_W-1:0] src_o,
  output logic [HI_W-1:0]  ofs_o,
  output logic [HI_W-1:0]  cmp_hi_o,
  output logic             bite_o
);

  localparam logic [HI_W-1:0] CMP_RST = HI_W'(1);

  // Compare high byte placed by a restart.
  function automatic logic [HI_W-1:0] restart_point(
    input logic [HI_W-1:0] hi,
    input logic [HI_W-1:0] ofs
  );
    return hi + ofs + HI_W'(1);
  endfunction

  // True when the next tick moves the counter onto {pt, all zeros}.
  function automatic logic reaches_point(
    input logic [CNT_W-1:0] cnt,
    input logic [HI_W-1:0]  pt
  );
    logic [HI_W-1:0] hi_next;
    hi_next = cnt[CNT_W-1:LO_W] + HI_W'(1);
    return (&cnt[LO_W-1:0]) && (hi_next == pt);
  endfunction

  logic             en_q;
  logic             lock_q;
  logic             idle_q;
  logic [SEL_W-1:0] src_q;
  logic [HI_W-1:0]  ofs_q;
  logic [HI_W-1:0]  cmp_q;
  logic             bite_q;

  logic             active;
  logic             kick_ok;
  logic [HI_W-1:0]  cmp_eff;
  logic             bite_d;

  assign active  = en_q | lock_q;
  assign kick_ok = kick_i & active;
  assign cmp_eff = kick_ok ? restart_point(cnt_i[CNT_W-1:LO_W], ofs_q) : cmp_q;
  assign bite_d  = active & tick_i & reaches_point(cnt_i, cmp_eff);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b1;
      lock_q <= 1'b0;
      idle_q <= 1'b0;
      src_q  <= SRC_DIV12;
      ofs_q  <= '0;
      cmp_q  <= CMP_RST;
    end else if (bite_q) begin
      en_q   <= 1'b1;
      lock_q <= 1'b0;
      idle_q <= 1'b0;
      src_q  <= SRC_DIV12;
      ofs_q  <= '0;
      cmp_q  <= CMP_RST;
    end else begin
      if (cfg_we_i) begin
        if (!lock_q) begin
          en_q <= cfg_i.en;
        end
        if (cfg_i.lock) begin
          lock_q <= 1'b1;
        end
        if (!active) begin
          idle_q <= cfg_i.idle_stop;
          src_q  <= cfg_i.src;
        end
      end
      if (ofs_we_i) begin
        ofs_q <= ofs_i;
      end
      if (kick_ok) begin
        cmp_q <= cmp_eff;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bite_q <= 1'b0;
    end else if (bite_q) begin
      bite_q <= 1'b0;
    end else begin
      bite_q <= bite_d;
    end
  end

  assign active_o    = active;
  assign lock_o      = lock_q;
  assign idle_stop_o = idle_q;
  assign src_o       = src_q;
  assign ofs_o       = ofs_q;
  assign cmp_hi_o    = cmp_q;
  assign bite_o      = bite_q;

endmodule

// File: rtl/lockable_watchdog.sv
module lockable_watchdog
  import wdt_pkg::*;
#(
  parameter int LO_W     = 8,
  parameter int HI_W     = 8,
  parameter int SLOW_DIV = 12,
  parameter int FAST_DIV = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ext_tick_i,
  input  logic                 cpu_idle_i,
  input  logic                 cfg_we_i,
  input  logic                 cfg_en_i,
  input  logic                 cfg_lock_i,
  input  logic                 cfg_idle_stop_i,
  input  logic [SEL_W-1:0]     cfg_src_i,
  input  logic                 ofs_we_i,
  input  logic [HI_W-1:0]      ofs_i,
  input  logic                 kick_i,
  output logic                 bite_o,
  output logic                 wdt_on_o,
  output logic                 lock_o,
  output logic                 idle_stop_o,
  output logic [SEL_W-1:0]     src_o,
  output logic [HI_W-1:0]      ofs_o,
  output logic [LO_W+HI_W-1:0] cnt_o,
  output logic [HI_W-1:0]      cmp_hi_o
);

  localparam int CNT_W = LO_W + HI_W;

  cfg_t             cfg_w;
  logic             tick_raw_w;
  logic             tick_run_w;
  logic [CNT_W-1:0] cnt_w;
  logic             bite_w;
  logic             idle_w;
  logic [SEL_W-1:0] src_w;

  assign cfg_w = '{en: cfg_en_i, lock: cfg_lock_i,
                   idle_stop: cfg_idle_stop_i, src: cfg_src_i};

  // Idle suspend gates the selected tick before it reaches the counter.
  assign tick_run_w = tick_raw_w & ~(idle_w & cpu_idle_i);

  wdt_tick_gen #(
    .SLOW_DIV (SLOW_DIV),
    .FAST_DIV (FAST_DIV)
  ) u_tick (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr_i      (bite_w),
    .ext_tick_i (ext_tick_i),
    .sel_i      (src_w),
    .tick_o     (tick_raw_w)
  );

  wdt_timer #(
    .LO_W (LO_W),
    .HI_W (HI_W)
  ) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr_i  (bite_w),
    .tick_i (tick_run_w),
    .cnt_o  (cnt_w)
  );

  wdt_ctrl #(
    .LO_W (LO_W),
    .HI_W (HI_W)
  ) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick_i      (tick_run_w),
    .cnt_i       (cnt_w),
    .cfg_we_i    (cfg_we_i),
    .cfg_i       (cfg_w),
    .ofs_we_i    (ofs_we_i),
    .ofs_i       (ofs_i),
    .kick_i      (kick_i),
    .active_o    (wdt_on_o),
    .lock_o      (lock_o),
    .idle_stop_o (idle_w),
    .src_o       (src_w),
    .ofs_o       (ofs_o),
    .cmp_hi_o    (cmp_hi_o),
    .bite_o      (bite_w)
  );

  assign bite_o      = bite_w;
  assign idle_stop_o = idle_w;
  assign src_o       = src_w;
  assign cnt_o       = cnt_w;

endmodule

// File: rtl/lockable_watchdog_chk.sv
module lockable_watchdog_chk #(
  parameter int LO_W = 8,
  parameter int HI_W = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 cpu_idle_i,
  input logic                 kick_i,
  input logic                 tick_run_w,
  input logic                 bite_o,
  input logic                 wdt_on_o,
  input logic                 lock_o,
  input logic                 idle_stop_o,
  input logic [2:0]           src_o,
  input logic [HI_W-1:0]      ofs_o,
  input logic [LO_W+HI_W-1:0] cnt_o,
  input logic [HI_W-1:0]      cmp_hi_o
);

  assert_bite_one_cycle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    bite_o |=> !bite_o);

  assert_bite_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    bite_o |=> (cnt_o == '0) && wdt_on_o && !lock_o && !idle_stop_o
               && (src_o == 3'd0) && (ofs_o == '0) && (cmp_hi_o == HI_W'(1)));

  assert_lock_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_o && !bite_o) |=> (lock_o && wdt_on_o));

  assert_cfg_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wdt_on_o && !bite_o) |=> ($stable(src_o) && $stable(idle_stop_o)));

  assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_stop_o && cpu_idle_i && !bite_o) |=> $stable(cnt_o));

  assert_off_no_bite_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !wdt_on_o |=> !bite_o);

  assert_off_cmp_kept_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!wdt_on_o && !bite_o) |=> $stable(cmp_hi_o));

  assert_cnt_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!bite_o && tick_run_w) |=> (cnt_o == $past(cnt_o) + (LO_W+HI_W)'(1)));

  assert_cnt_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!bite_o && !tick_run_w) |=> $stable(cnt_o));

  assert_cmp_load_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (kick_i && wdt_on_o && !bite_o) |=>
      (cmp_hi_o == HI_W'($past(cnt_o[LO_W+HI_W-1:LO_W]) + $past(ofs_o) + HI_W'(1))));

endmodule

bind lockable_watchdog lockable_watchdog_chk #(
  .LO_W (LO_W),
  .HI_W (HI_W)
) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .cpu_idle_i  (cpu_idle_i),
  .kick_i      (kick_i),
  .tick_run_w  (tick_run_w),
  .bite_o      (bite_o),
  .wdt_on_o    (wdt_on_o),
  .lock_o      (lock_o),
  .idle_stop_o (idle_stop_o),
  .src_o       (src_o),
  .ofs_o       (ofs_o),
  .cnt_o       (cnt_o),
  .cmp_hi_o    (cmp_hi_o)
);

// File: tb/lockable_watchdog_tb_top.sv
`timescale 1ns/1ps
module lockable_watchdog_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ext_tick_i = 1'b0;
  logic        cpu_idle_i = 1'b0;
  logic        cfg_we_i = 1'b0;
  logic        cfg_en_i = 1'b0;
  logic        cfg_lock_i = 1'b0;
  logic        cfg_idle_stop_i = 1'b0;
  logic [2:0]  cfg_src_i = 3'd0;
  logic        ofs_we_i = 1'b0;
  logic [7:0]  ofs_i = 8'd0;
  logic        kick_i = 1'b0;
  logic        bite_o, wdt_on_o, lock_o, idle_stop_o;
  logic [2:0]  src_o;
  logic [7:0]  ofs_o, cmp_hi_o;
  logic [15:0] cnt_o;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  always #2 clk = ~clk;

  lockable_watchdog dut_i (
    .clk(clk), .rst_n(rst_n), .ext_tick_i(ext_tick_i), .cpu_idle_i(cpu_idle_i),
    .cfg_we_i(cfg_we_i), .cfg_en_i(cfg_en_i), .cfg_lock_i(cfg_lock_i),
    .cfg_idle_stop_i(cfg_idle_stop_i), .cfg_src_i(cfg_src_i),
    .ofs_we_i(ofs_we_i), .ofs_i(ofs_i), .kick_i(kick_i),
    .bite_o(bite_o), .wdt_on_o(wdt_on_o), .lock_o(lock_o),
    .idle_stop_o(idle_stop_o), .src_o(src_o), .ofs_o(ofs_o),
    .cnt_o(cnt_o), .cmp_hi_o(cmp_hi_o)
  );

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run hung, actual=%0d expected<=190000 cycles", cyc);
      summary();
    end
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cfg_wr(input bit en, input bit lk, input bit idl, input logic [2:0] s);
    @(negedge clk);
    cfg_en_i = en; cfg_lock_i = lk; cfg_idle_stop_i = idl; cfg_src_i = s; cfg_we_i = 1'b1;
    @(negedge clk);
    cfg_we_i = 1'b0; cfg_lock_i = 1'b0;
  endtask

  task automatic ofs_wr(input logic [7:0] v);
    @(negedge clk);
    ofs_i = v; ofs_we_i = 1'b1;
    @(negedge clk);
    ofs_we_i = 1'b0;
  endtask

  // Caller stands at a falling edge.
  task automatic kick_now();
    kick_i = 1'b1;
    @(negedge clk);
    kick_i = 1'b0;
  endtask

  // Off, pick source, park a far compare point, turn on, then load offset o.
  task automatic prepare(input logic [2:0] s, input logic [7:0] o);
    cfg_wr(1'b0, 1'b0, 1'b0, 3'd0);
    cfg_wr(1'b0, 1'b0, 1'b0, s);
    ofs_wr(8'hFF);
    while (cnt_o[7:0] >= 8'd200) @(negedge clk);
    cfg_wr(1'b1, 1'b0, 1'b0, s);
    kick_now();
    ofs_wr(o);
  endtask

  // Restart at the current falling edge; k = rising edges until bite seen.
  task automatic measure(output int k, output int lo, output int hi, output int cmpv);
    lo = int'(cnt_o[7:0]);
    hi = int'(cnt_o[15:8]);
    kick_i = 1'b1;
    @(posedge clk);
    #1;
    kick_i = 1'b0;
    cmpv = int'(cmp_hi_o);
    k = 1;
    while (!bite_o && k < 70000) begin
      @(posedge clk);
      #1;
      k++;
    end
  endtask

  task automatic after_bite();
    @(posedge clk);
    #1;
    chk(bite_o == 1'b0, "R9 request lasts one cycle", bite_o, 0);
    chk(cnt_o == 16'd0 && wdt_on_o && !lock_o && !idle_stop_o && src_o == 3'd0
        && ofs_o == 8'd0 && cmp_hi_o == 8'd1, "R9 registers back to defaults",
        {lock_o, wdt_on_o, cmp_hi_o, cnt_o}, {1'b0, 1'b1, 8'd1, 16'd0});
  endtask

  initial begin
    int k, lo, hi, cmpv, c0, n;
    int offs[3] = '{0, 1, 2};
    int tgts[4] = '{0, 1, 128, 255};

    repeat (3) @(negedge clk);
    chk(wdt_on_o && !lock_o && src_o == 3'd0 && !idle_stop_o && ofs_o == 8'd0
        && cnt_o == 16'd0 && cmp_hi_o == 8'd1, "R1 reset state",
        {wdt_on_o, lock_o, src_o, ofs_o, cmp_hi_o}, {1'b1, 1'b0, 3'd0, 8'd0, 8'd1});
    rst_n = 1'b1;

    // R2: default timeout
    k = 0;
    do begin
      @(posedge clk);
      #1;
      k++;
    end while (!bite_o && k < 5000);
    chk(k == 3072, "R2 default timeout edges", k, 3072);
    after_bite();

    // R7: frozen while on; R5: disable
    cfg_wr(1'b1, 1'b0, 1'b1, 3'd2);
    chk(src_o == 3'd0 && !idle_stop_o, "R7 writes ignored while on", src_o, 0);
    cfg_wr(1'b0, 1'b0, 1'b0, 3'd0);
    chk(!wdt_on_o, "R5 enable cleared turns off", wdt_on_o, 0);
    cfg_wr(1'b0, 1'b0, 1'b0, 3'd2);
    chk(src_o == 3'd2, "R7 source accepted while off", src_o, 2);

    // R10: off -> restart ignored, no request
    ofs_wr(8'd3);
    kick_now();
    chk(cmp_hi_o == 8'd1, "R10 restart ignored while off", cmp_hi_o, 1);
    n = 0;
    repeat (600) begin
      @(posedge clk);
      #1;
      if (bite_o) n++;
    end
    chk(n == 0, "R10 no request while off", n, 0);

    // R8: idle suspend
    cfg_wr(1'b0, 1'b0, 1'b1, 3'd2);
    cpu_idle_i = 1'b1;
    @(negedge clk);
    c0 = int'(cnt_o);
    repeat (40) @(negedge clk);
    chk(int'(cnt_o) == c0, "R8 counter holds in idle", cnt_o, c0);
    cpu_idle_i = 1'b0;
    c0 = int'(cnt_o);
    repeat (10) @(negedge clk);
    chk(int'(cnt_o) == ((c0 + 10) & 16'hFFFF), "R8 counter runs when not idle", cnt_o, c0 + 10);
    cfg_wr(1'b0, 1'b0, 1'b0, 3'd2);
    cpu_idle_i = 1'b1;
    c0 = int'(cnt_o);
    repeat (10) @(negedge clk);
    chk(int'(cnt_o) == ((c0 + 10) & 16'hFFFF), "R8 idle ignored when suspend clear", cnt_o, c0 + 10);
    cpu_idle_i = 1'b0;

    // R3 / R11 sweep, every clock a tick
    foreach (offs[i]) begin
      foreach (tgts[j]) begin
        prepare(3'd2, 8'(offs[i]));
        @(negedge clk);
        while (int'(cnt_o[7:0]) != tgts[j]) @(negedge clk);
        measure(k, lo, hi, cmpv);
        chk(k == 256 * offs[i] + 256 - lo, "R3 timeout ticks", k, 256 * offs[i] + 256 - lo);
        chk(cmpv == ((hi + offs[i] + 1) & 255), "R11 compare high byte", cmpv, (hi + offs[i] + 1) & 255);
        after_bite();
      end
    end
    prepare(3'd2, 8'd255);
    @(negedge clk);
    while (cnt_o[7:0] != 8'd0) @(negedge clk);
    measure(k, lo, hi, cmpv);
    chk(k == 65536, "R3 largest offset timeout", k, 65536);
    chk(cmpv == ((hi + 256) & 255), "R11 compare wraps", cmpv, (hi + 256) & 255);
    after_bite();

    // R4: divide-by-4
    prepare(3'd1, 8'd0);
    @(negedge clk);
    measure(k, lo, hi, cmpv);
    n = 256 - lo;
    chk(k >= 4 * n - 3 && k <= 4 * n, "R4 divide-by-4 window", k, 4 * n);
    after_bite();

    // R4: unused code 5 behaves as divide-by-12
    prepare(3'd5, 8'd0);
    @(negedge clk);
    measure(k, lo, hi, cmpv);
    n = 256 - lo;
    chk(k >= 12 * n - 11 && k <= 12 * n, "R4 code 5 as divide-by-12", k, 12 * n);
    after_bite();

    // R4: external tick
    prepare(3'd3, 8'd1);
    @(negedge clk);
    c0 = int'(cnt_o);
    repeat (20) @(negedge clk);
    chk(int'(cnt_o) == c0, "R4 external source holds without ticks", cnt_o, c0);
    lo = int'(cnt_o[7:0]);
    kick_i = 1'b1;
    @(posedge clk);
    #1;
    kick_i = 1'b0;
    k = 0;
    while (!bite_o && k < 2000) begin
      @(negedge clk);
      ext_tick_i = 1'b1;
      @(posedge clk);
      #1;
      ext_tick_i = 1'b0;
      k++;
    end
    chk(k == 512 - lo, "R4 external tick count", k, 512 - lo);
    after_bite();

    // R6: lock
    cfg_wr(1'b0, 1'b0, 1'b0, 3'd0);
    cfg_wr(1'b0, 1'b0, 1'b0, 3'd2);
    ofs_wr(8'hFF);
    while (cnt_o[7:0] >= 8'd200) @(negedge clk);
    cfg_wr(1'b0, 1'b1, 1'b0, 3'd2);
    kick_now();
    chk(wdt_on_o && lock_o, "R6 lock bit turns on", {wdt_on_o, lock_o}, 3);
    cfg_wr(1'b0, 1'b0, 1'b0, 3'd2);
    chk(wdt_on_o && lock_o, "R6 locked stays on", {wdt_on_o, lock_o}, 3);
    cfg_wr(1'b0, 1'b0, 1'b1, 3'd1);
    chk(src_o == 3'd2 && !idle_stop_o, "R7 frozen while locked", src_o, 2);
    ofs_wr(8'd0);
    @(negedge clk);
    measure(k, lo, hi, cmpv);
    chk(k == 256 - lo, "R6 locked timeout fires", k, 256 - lo);
    after_bite();

    summary();
  end

endmodule